// File: doc/BRIEF.md
# ATA Taskfile Command Issue Sequencer

This block issues one ATA read or write command to a device through a byte-wide taskfile register port. A single start pulse hands it a 48-bit start sector, a 16-bit sector count, a transfer direction, an addressing-mode flag (28-bit or 48-bit) and a flag that selects DMA or programmed transfer. The block captures these values. It polls the device status byte until the device is idle and ready. It then writes the parameter registers one per cycle in the order the addressing mode requires, and writes the command opcode last.

After the command is written, the block waits for the device to ask for data. It then waits for an external engine to report that the data phase has finished. It reads the final status and reports either a one-cycle done pulse or a one-cycle error pulse. The error pulse comes with a code that names the phase that failed. Each wait has a cycle budget set on an input port, so a silent device cannot stall the block. The data movement itself, the DMA engine and the bus timing belong to other blocks.

Top module: `ata_cmd_seq`

## Requirements
- R1: After reset, `tf_wr`, `done` and `error` are low and `err_code` is 0.
- R2: `start` is taken only while the block is idle. A pulse during a command changes neither that command's register writes nor its outcome, and it produces no second command.
- R3: No register is written until the status byte has shown bit 7 (busy) clear and then bit 6 (ready) set with bit 7 still clear.
- R4: The first write of every command puts 0x00 into the device register. Register addresses are: 2 = sector count, 3 = LBA low, 4 = LBA mid, 5 = LBA high, 6 = device, 7 = command.
- R5: In 48-bit mode, the writes after the first one are, in this order: count[15:8] and count[7:0] to address 2; LBA[47:40] to 5, LBA[39:32] to 4, LBA[31:24] to 3; LBA[23:16] to 5, LBA[15:8] to 4, LBA[7:0] to 3; 0x40 to 6; then the opcode to 7.
- R6: In 28-bit mode, the writes after the first one are: count[7:0] to 2, LBA[23:16] to 5, LBA[15:8] to 4, LBA[7:0] to 3, 0x40 OR LBA[27:24] to 6, then the opcode to 7.
- R7: The opcode is chosen as follows. 48-bit mode: read DMA 0x25, read programmed 0x29, write DMA 0x35, write programmed 0x39. 28-bit mode: read DMA 0xC8, read programmed 0xC4, write DMA 0xCA, write programmed 0x30. The command write is the last write of the command.
- R8: After the command write, status is judged only when bit 7 is clear. If bit 0 (error) is set, the block fails with code 4. If bit 3 (data request) is set, the block moves on to wait for `xfer_done`.
- R9: After `xfer_done`, once bit 7 clears, the command succeeds only if bits 7, 6, 5, 3 and 0 read 0, 1, 0, 0, 0. Any other value fails with code 7.
- R10: Each wait phase fails if its condition has not been met by the end of `wait_limit` cycles in that phase. The codes are: busy 1, ready 2, data request 3, transfer 5, final busy 6. When busy stays set, the error pulse is seen `wait_limit`+1 cycles after the start cycle.
- R11: `done` and `error` are single-cycle pulses and are never high together. `err_code` holds the last failure code until the next accepted start clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse for one command |
| start_lba | input | 48 | First sector address |
| sec_count | input | 16 | Number of sectors |
| dir_write | input | 1 | 1 = write, 0 = read |
| mode_lba48 | input | 1 | 1 = 48-bit addressing |
| mode_dma | input | 1 | 1 = DMA opcode, 0 = programmed opcode |
| wait_limit | input | TMO_W | Cycle budget for each wait phase |
| dev_status | input | 8 | Device status byte |
| xfer_done | input | 1 | Data phase finished |
| tf_wr | output | 1 | Register write strobe |
| tf_addr | output | 3 | Register address |
| tf_wdata | output | 8 | Register write data |
| done | output | 1 | Command completed well |
| error | output | 1 | Command failed |
| err_code | output | 3 | Failure code |

## Verification
The final status judgement and a new start request can fall in the same cycle. The bench raises `start` in the very cycle the good final status is presented. It expects that cycle to yield only the done pulse. It then holds a ready status for fifteen more cycles and expects no register write, which shows the start was dropped and not queued. A second start arriving while the busy bit is still set is also judged on the write log: the log must match the first request's parameters exactly.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;

    localparam int LBA_W  = 48;
    localparam int CNT_W  = 16;
    localparam int STEP_W = 4;

    localparam logic [2:0] TF_COUNT   = 3'd2;
    localparam logic [2:0] TF_LBA_LO  = 3'd3;
    localparam logic [2:0] TF_LBA_MID = 3'd4;
    localparam logic [2:0] TF_LBA_HI  = 3'd5;
    localparam logic [2:0] TF_DEVICE  = 3'd6;
    localparam logic [2:0] TF_COMMAND = 3'd7;

    localparam logic [7:0] DEV_LBA_MODE = 8'h40;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BSY,
        ST_RDY,
        ST_WRITE,
        ST_DRQ,
        ST_XFER,
        ST_END
    } seq_state_e;

    typedef enum logic [2:0] {
        EC_NONE       = 3'd0,
        EC_TO_BSY     = 3'd1,
        EC_TO_RDY     = 3'd2,
        EC_TO_DRQ     = 3'd3,
        EC_DEV_START  = 3'd4,
        EC_TO_XFER    = 3'd5,
        EC_TO_END     = 3'd6,
        EC_END_STATUS = 3'd7
    } seq_err_e;

    typedef struct packed {
        seq_state_e        state;
        logic [STEP_W-1:0] step;
        logic [LBA_W-1:0]  lba;
        logic [CNT_W-1:0]  count;
        logic              lba48;
        logic [7:0]        opcode;
        logic              tf_wr;
        logic [2:0]        tf_addr;
        logic [7:0]        tf_wdata;
        logic              done;
        logic              error;
        seq_err_e          err_code;
    } seq_regs_t;

    function automatic logic [7:0] pick_opcode(input logic wr, input logic l48, input logic dma);
        logic [7:0] op;
        unique case ({l48, wr, dma})
            3'b100:  op = 8'h29;
            3'b101:  op = 8'h25;
            3'b110:  op = 8'h39;
            3'b111:  op = 8'h35;
            3'b000:  op = 8'hC4;
            3'b001:  op = 8'hC8;
            3'b010:  op = 8'h30;
            default: op = 8'hCA;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/ata_status_eval.sv
module ata_status_eval (
    input  logic [7:0] status,
    output logic       busy,
    output logic       ready,
    output logic       start_fail,
    output logic       start_go,
    output logic       end_good,
    output logic       end_bad
);
    logic unused_bits;
    logic err_bit;
    logic end_pattern;

    assign unused_bits = ^{status[4], status[2:1]};
    assign err_bit     = status[0];
    assign busy        = status[7];
    assign ready       = status[6] && !status[7];

    // Start phase: error wins over data request once busy is clear.
    assign start_fail  = !busy && err_bit;
    assign start_go    = !busy && !err_bit && status[3];

    // End phase: bits 7,6,5,3 must read 0,1,0,0 and error must be clear.
    assign end_pattern = (status[7:5] == 3'b010) && !status[3] && !err_bit;
    assign end_good    = !busy && end_pattern;
    assign end_bad     = !busy && !end_pattern;
endmodule

// File: rtl/ata_tf_step.sv
module ata_tf_step
    import ata_seq_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    input  logic              lba48,
    input  logic [LBA_W-1:0]  lba,
    input  logic [CNT_W-1:0]  count,
    input  logic [7:0]        opcode,
    output logic [2:0]        addr,
    output logic [7:0]        data,
    output logic              last
);
    always_comb begin
        addr = TF_COMMAND;
        data = opcode;
        if (lba48) begin
            unique case (step)
                4'd0:    begin addr = TF_DEVICE;  data = 8'h00;         end
                4'd1:    begin addr = TF_COUNT;   data = count[15:8];   end
                4'd2:    begin addr = TF_COUNT;   data = count[7:0];    end
                4'd3:    begin addr = TF_LBA_HI;  data = lba[47:40];    end
                4'd4:    begin addr = TF_LBA_MID; data = lba[39:32];    end
                4'd5:    begin addr = TF_LBA_LO;  data = lba[31:24];    end
                4'd6:    begin addr = TF_LBA_HI;  data = lba[23:16];    end
                4'd7:    begin addr = TF_LBA_MID; data = lba[15:8];     end
                4'd8:    begin addr = TF_LBA_LO;  data = lba[7:0];      end
                4'd9:    begin addr = TF_DEVICE;  data = DEV_LBA_MODE;  end
                default: begin addr = TF_COMMAND; data = opcode;        end
            endcase
        end else begin
            unique case (step)
                4'd0:    begin addr = TF_DEVICE;  data = 8'h00;         end
                4'd1:    begin addr = TF_COUNT;   data = count[7:0];    end
                4'd2:    begin addr = TF_LBA_HI;  data = lba[23:16];    end
                4'd3:    begin addr = TF_LBA_MID; data = lba[15:8];     end
                4'd4:    begin addr = TF_LBA_LO;  data = lba[7:0];      end
                4'd5:    begin addr = TF_DEVICE;  data = DEV_LBA_MODE | {4'h0, lba[27:24]}; end
                default: begin addr = TF_COMMAND; data = opcode;        end
            endcase
        end
        last = (addr == TF_COMMAND);
    end
endmodule

// File: rtl/ata_wait_timer.sv
module ata_wait_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = clr ? '0 : cnt_q + TMO_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == limit - TMO_W'(1));
endmodule

// File: rtl/ata_cmd_seq.sv
module ata_cmd_seq
    import ata_seq_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [47:0]      start_lba,
    input  logic [15:0]      sec_count,
    input  logic             dir_write,
    input  logic             mode_lba48,
    input  logic             mode_dma,
    input  logic [TMO_W-1:0] wait_limit,
    input  logic [7:0]       dev_status,
    input  logic             xfer_done,
    output logic             tf_wr,
    output logic [2:0]       tf_addr,
    output logic [7:0]       tf_wdata,
    output logic             done,
    output logic             error,
    output logic [2:0]       err_code
);
    seq_regs_t r_d, r_q;

    logic st_busy, st_ready, st_start_fail, st_start_go, st_end_good, st_end_bad;
    logic       step_last;
    logic [2:0] step_addr;
    logic [7:0] step_data;
    logic       tmr_clr, tmr_expired;

    ata_status_eval u_status (
        .status     (dev_status),
        .busy       (st_busy),
        .ready      (st_ready),
        .start_fail (st_start_fail),
        .start_go   (st_start_go),
        .end_good   (st_end_good),
        .end_bad    (st_end_bad)
    );

    ata_tf_step u_step (
        .step   (r_q.step),
        .lba48  (r_q.lba48),
        .lba    (r_q.lba),
        .count  (r_q.count),
        .opcode (r_q.opcode),
        .addr   (step_addr),
        .data   (step_data),
        .last   (step_last)
    );

    ata_wait_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .limit   (wait_limit),
        .expired (tmr_expired)
    );

    always_comb begin
        r_d       = r_q;
        r_d.tf_wr = 1'b0;
        r_d.done  = 1'b0;
        r_d.error = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state    = ST_BSY;
                    r_d.lba      = start_lba;
                    r_d.count    = sec_count;
                    r_d.lba48    = mode_lba48;
                    r_d.opcode   = pick_opcode(dir_write, mode_lba48, mode_dma);
                    r_d.step     = '0;
                    r_d.err_code = EC_NONE;
                end
            end
            ST_BSY: begin
                if (!st_busy) begin
                    r_d.state = ST_RDY;
                end else if (tmr_expired) begin
                    r_d.state = ST_IDLE; r_d.error = 1'b1; r_d.err_code = EC_TO_BSY;
                end
            end
            ST_RDY: begin
                if (st_ready) begin
                    r_d.state = ST_WRITE;
                    r_d.step  = '0;
                end else if (tmr_expired) begin
                    r_d.state = ST_IDLE; r_d.error = 1'b1; r_d.err_code = EC_TO_RDY;
                end
            end
            ST_WRITE: begin
                r_d.tf_wr    = 1'b1;
                r_d.tf_addr  = step_addr;
                r_d.tf_wdata = step_data;
                r_d.step     = r_q.step + STEP_W'(1);
                if (step_last) r_d.state = ST_DRQ;
            end
            ST_DRQ: begin
                if (st_start_fail) begin
                    r_d.state = ST_IDLE; r_d.error = 1'b1; r_d.err_code = EC_DEV_START;
                end else if (st_start_go) begin
                    r_d.state = ST_XFER;
                end else if (tmr_expired) begin
                    r_d.state = ST_IDLE; r_d.error = 1'b1; r_d.err_code = EC_TO_DRQ;
                end
            end
            ST_XFER: begin
                if (xfer_done) begin
                    r_d.state = ST_END;
                end else if (tmr_expired) begin
                    r_d.state = ST_IDLE; r_d.error = 1'b1; r_d.err_code = EC_TO_XFER;
                end
            end
            ST_END: begin
                if (st_end_good) begin
                    r_d.state = ST_IDLE; r_d.done = 1'b1;
                end else if (st_end_bad) begin
                    r_d.state = ST_IDLE; r_d.error = 1'b1; r_d.err_code = EC_END_STATUS;
                end else if (tmr_expired) begin
                    r_d.state = ST_IDLE; r_d.error = 1'b1; r_d.err_code = EC_TO_END;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    assign tmr_clr = (r_d.state != r_q.state);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tf_wr    = r_q.tf_wr;
    assign tf_addr  = r_q.tf_addr;
    assign tf_wdata = r_q.tf_wdata;
    assign done     = r_q.done;
    assign error    = r_q.error;
    assign err_code = r_q.err_code;
endmodule

// File: rtl/ata_cmd_seq_chk.sv
module ata_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] dev_status,
    input logic       tf_wr,
    input logic [2:0] tf_addr,
    input logic [7:0] tf_wdata,
    input logic       done,
    input logic       error,
    input logic [2:0] err_code
);
    logic unused_bits;
    assign unused_bits = ^{dev_status[4], dev_status[2:1]};

    a_r11_done_error_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_error_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error);

    a_r10_error_has_code: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (err_code != 3'd0));

    a_r7_cmd_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (tf_wr && tf_addr == 3'd7) |-> (tf_wdata inside {8'h25, 8'h29, 8'h35, 8'h39,
                                                           8'hC8, 8'hC4, 8'hCA, 8'h30}));

    a_r7_cmd_last: assert property (@(posedge clk) disable iff (!rst_n)
        (tf_wr && tf_addr == 3'd7) |=> !tf_wr);

    a_r3_first_write_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tf_wr) |-> ($past(dev_status[6], 2) && !$past(dev_status[7], 2)));

    a_r9_done_needs_end_status: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(dev_status[7:5]) == 3'b010 && !$past(dev_status[3]) && !$past(dev_status[0])));
endmodule

bind ata_cmd_seq ata_cmd_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_status (dev_status),
    .tf_wr      (tf_wr),
    .tf_addr    (tf_addr),
    .tf_wdata   (tf_wdata),
    .done       (done),
    .error      (error),
    .err_code   (err_code)
);

// File: tb/ata_cmd_seq_bench.sv
module ata_cmd_seq_bench;
    localparam int TMO_W = 16;
    localparam int LIMIT = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [47:0]      start_lba = '0;
    logic [15:0]      sec_count = '0;
    logic             dir_write = 1'b0;
    logic             mode_lba48 = 1'b0;
    logic             mode_dma = 1'b0;
    logic [TMO_W-1:0] wait_limit = TMO_W'(LIMIT);
    logic [7:0]       dev_status = 8'h80;
    logic             xfer_done = 1'b0;
    logic             tf_wr, done, error;
    logic [2:0]       tf_addr, err_code;
    logic [7:0]       tf_wdata;

    int tests = 0;
    int fails = 0;

    logic [2:0] log_a [0:31];
    logic [7:0] log_d [0:31];
    int         log_n = 0;
    logic [2:0] exp_a [0:15];
    logic [7:0] exp_d [0:15];
    int         exp_n = 0;

    always #5 clk = ~clk;

    ata_cmd_seq #(.TMO_W(TMO_W)) u_ata_cmd_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_lba(start_lba),
        .sec_count(sec_count), .dir_write(dir_write), .mode_lba48(mode_lba48),
        .mode_dma(mode_dma), .wait_limit(wait_limit), .dev_status(dev_status),
        .xfer_done(xfer_done), .tf_wr(tf_wr), .tf_addr(tf_addr), .tf_wdata(tf_wdata),
        .done(done), .error(error), .err_code(err_code)
    );

    always @(negedge clk) begin
        if (rst_n && tf_wr) begin
            if (log_n < 32) begin
                log_a[log_n] = tf_addr;
                log_d[log_n] = tf_wdata;
            end
            log_n = log_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    function automatic logic [7:0] exp_opcode(input bit wr, input bit l48, input bit dma);
        if (l48) return wr ? (dma ? 8'h35 : 8'h39) : (dma ? 8'h25 : 8'h29);
        return wr ? (dma ? 8'hCA : 8'h30) : (dma ? 8'hC8 : 8'hC4);
    endfunction

    task automatic push(input logic [2:0] a, input logic [7:0] d);
        exp_a[exp_n] = a;
        exp_d[exp_n] = d;
        exp_n++;
    endtask

    task automatic build_exp(input logic [47:0] lba, input logic [15:0] cnt,
                             input bit l48, input logic [7:0] op);
        exp_n = 0;
        push(3'd6, 8'h00);
        if (l48) begin
            push(3'd2, cnt[15:8]);  push(3'd2, cnt[7:0]);
            push(3'd5, lba[47:40]); push(3'd4, lba[39:32]); push(3'd3, lba[31:24]);
            push(3'd5, lba[23:16]); push(3'd4, lba[15:8]);  push(3'd3, lba[7:0]);
            push(3'd6, 8'h40);
        end else begin
            push(3'd2, cnt[7:0]);
            push(3'd5, lba[23:16]); push(3'd4, lba[15:8]); push(3'd3, lba[7:0]);
            push(3'd6, 8'h40 | {4'h0, lba[27:24]});
        end
        push(3'd7, op);
    endtask

    task automatic wait_err(input logic [2:0] code, input string req);
        int cyc = 0;
        while (!error && !done && cyc < LIMIT + 20) begin
            @(negedge clk);
            cyc++;
        end
        check(error === 1'b1, req, "error pulse after hang", error, 1);
        check(err_code === code, req, "error code", err_code, code);
        @(negedge clk);
        check(error === 1'b0, "R11", "error is one cycle", error, 0);
    endtask

    // hang: 0 none, 1 busy, 2 ready, 3 data request, 4 device error, 5 transfer, 6 final busy
    task automatic run_cmd(input logic [47:0] lba, input logic [15:0] cnt, input bit wr,
                           input bit l48, input bit dma, input int bsy_hold, input int hang,
                           input logic [7:0] end_st, input bit restart, input bit collide);
        int  cyc;
        bit  nowr;
        bit  good;
        logic [7:0] op;
        op = exp_opcode(wr, l48, dma);
        build_exp(lba, cnt, l48, op);
        @(negedge clk);
        log_n = 0;
        dev_status = 8'h80;
        start_lba = lba; sec_count = cnt; dir_write = wr; mode_lba48 = l48; mode_dma = dma;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (hang == 1) begin
            cyc = 1;
            while (!error && cyc < LIMIT + 20) begin
                @(negedge clk);
                cyc++;
            end
            check(error === 1'b1 && err_code == 3'd1, "R10", "busy timeout code", err_code, 1);
            check(cyc == LIMIT + 1, "R10", "busy timeout cycle", cyc, LIMIT + 1);
            check(log_n == 0, "R3", "no writes while busy", log_n, 0);
            return;
        end
        nowr = 1'b1;
        for (int i = 0; i < bsy_hold; i++) begin
            start = restart && (i == 0);
            if (restart) begin
                start_lba = ~lba; sec_count = ~cnt; mode_lba48 = ~l48; dir_write = ~wr;
            end
            @(negedge clk);
            nowr &= !tf_wr;
        end
        start = 1'b0;
        dev_status = 8'h00;
        repeat (2) begin
            @(negedge clk);
            nowr &= !tf_wr;
        end
        check(nowr && log_n == 0, "R3", "no write before ready", log_n, 0);
        if (hang == 2) begin
            wait_err(3'd2, "R10");
            check(log_n == 0, "R3", "no write when never ready", log_n, 0);
            return;
        end
        dev_status = 8'h50;
        cyc = 0;
        while (!(tf_wr && tf_addr == 3'd7) && cyc < 30) begin
            @(negedge clk);
            cyc++;
        end
        dev_status = 8'h80;
        repeat (2) @(negedge clk);
        if (hang == 3) begin
            dev_status = 8'h50;
            wait_err(3'd3, "R10");
            return;
        end
        if (hang == 4) begin
            dev_status = 8'h59;
            wait_err(3'd4, "R8");
            return;
        end
        dev_status = 8'h58;
        repeat (3) @(negedge clk);
        if (hang == 5) begin
            wait_err(3'd5, "R10");
            return;
        end
        dev_status = 8'h80;
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        @(negedge clk);
        if (hang == 6) begin
            wait_err(3'd6, "R10");
            return;
        end
        dev_status = end_st;
        start = collide;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && !error && cyc < 5) begin
            @(negedge clk);
            cyc++;
        end
        good = ((end_st & 8'hE9) == 8'h40);
        check(!(done && error), "R11", "done and error exclusive", {done, error}, 0);
        if (good) begin
            check(done === 1'b1, "R9", "done on good end status", end_st, 8'h40);
            check(err_code == 3'd0, "R11", "code cleared on success", err_code, 0);
        end else begin
            check(error === 1'b1 && err_code == 3'd7, "R9", "bad end status code", err_code, 7);
        end
        @(negedge clk);
        check(!done && !error, "R11", "outcome is one cycle", {done, error}, 0);
        check(log_n == exp_n, l48 ? "R5" : "R6", "write count", log_n, exp_n);
        for (int k = 0; k < exp_n && k < log_n; k++) begin
            check(log_a[k] == exp_a[k] && log_d[k] == exp_d[k],
                  (k == 0) ? "R4" : ((k == exp_n - 1) ? "R7" : (l48 ? "R5" : "R6")),
                  $sformatf("write %0d addr/data", k), {log_a[k], log_d[k]}, {exp_a[k], exp_d[k]});
        end
        if (restart)
            check(log_n == exp_n, "R2", "restart during command ignored", log_n, exp_n);
        if (collide) begin
            dev_status = 8'h50;
            nowr = 1'b1;
            repeat (15) begin
                @(negedge clk);
                nowr &= !tf_wr && !error;
            end
            check(nowr, "R2", "start during final check not taken", log_n, exp_n);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(tf_wr === 1'b0 && done === 1'b0 && error === 1'b0, "R1", "outputs in reset",
              {tf_wr, done, error}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(err_code === 3'd0 && tf_wr === 1'b0, "R1", "state after reset", err_code, 0);

        run_cmd(48'hA1B2_C3D4_E5F6, 16'h1234, 1'b0, 1'b1, 1'b1, 3, 0, 8'h50, 1'b0, 1'b0);
        run_cmd(48'h0102_0304_0506, 16'h0100, 1'b1, 1'b1, 1'b0, 1, 0, 8'h50, 1'b0, 1'b0);
        run_cmd(48'h0000_0A12_3456, 16'h00FF, 1'b1, 1'b0, 1'b1, 2, 0, 8'h50, 1'b0, 1'b0);
        run_cmd(48'hFFFF_FFFF_FFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 4, 0, 8'h50, 1'b0, 1'b0);
        run_cmd(48'h0000_0000_0000, 16'h0001, 1'b1, 1'b0, 1'b0, 1, 0, 8'h50, 1'b0, 1'b0);
        run_cmd(48'h1111_2222_3333, 16'h0010, 1'b0, 1'b0, 1'b1, 1, 0, 8'h50, 1'b0, 1'b0);
        run_cmd(48'h5566_7788_99AA, 16'h0042, 1'b0, 1'b1, 1'b0, 5, 0, 8'h50, 1'b1, 1'b0);
        run_cmd(48'h0000_0000_1000, 16'h0008, 1'b1, 1'b1, 1'b1, 2, 0, 8'h50, 1'b0, 1'b1);
        run_cmd(48'h0000_0000_0001, 16'h0002, 1'b0, 1'b1, 1'b1, 2, 0, 8'h58, 1'b0, 1'b0);
        run_cmd(48'h0000_0000_0001, 16'h0002, 1'b0, 1'b1, 1'b1, 2, 0, 8'h51, 1'b0, 1'b0);
        run_cmd(48'h0000_0000_0001, 16'h0002, 1'b0, 1'b0, 1'b1, 2, 0, 8'h70, 1'b0, 1'b0);
        run_cmd(48'h0000_0000_0001, 16'h0002, 1'b1, 1'b0, 1'b0, 2, 0, 8'h00, 1'b0, 1'b0);
        for (int h = 1; h <= 6; h++)
            run_cmd(48'h0000_1234_5678, 16'h0003, 1'b1, 1'b1, 1'b0, 2, h, 8'h50, 1'b0, 1'b0);
        run_cmd(48'h0000_0000_2000, 16'h0004, 1'b0, 1'b0, 1'b0, 1, 0, 8'h50, 1'b0, 1'b0);

        for (int n = 0; n < 40; n++) begin
            logic [47:0] rl;
            logic [7:0]  es;
            rl = {16'($urandom), $urandom};
            es = ($urandom % 2 == 0) ? 8'h50 : 8'($urandom) & 8'h7F;
            run_cmd(rl, 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    1 + int'($urandom % 6), 0, es, 1'($urandom % 4 == 0), 1'b0);
        end
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule